// File: doc/BRIEF.md
# Composite Sync Separator and Burst Gate

This block sits in the digital timing section of a video encoder. It runs on the clock at four times the colour subcarrier frequency: 14.31818 MHz for NTSC and 17.73448 MHz for PAL. It watches an active-low composite sync input, which must already be synchronous to that clock. It counts how many clock edges each low pulse lasts. When the pulse ends, it sorts the pulse into one of three kinds:

- a short equalizing pulse;
- a line (horizontal) sync pulse;
- a broad vertical pulse. The high gaps between broad pulses are the serrations.

The sorting depends on where the trailing edge falls against an acceptance window, and the window limits follow the selected standard.

Only a pulse that passes the window produces a one-cycle line strobe and opens the colour burst gate. Pulses that are too short or too long never open the gate. The first accepted line pulse after a broad vertical pulse also raises a one-cycle frame-start strobe, which the subcarrier phase generator uses. The block also provides a copy of the sync input, delayed by a fixed number of register stages, for insertion on the luma path.

The interface has no data stream. Every pin is a plain control or status level or strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `sync_sep_gate`

## Requirements
- R1: While rst_n is low, h_valid, burst_gate and frame_start are 0 and sync_dly_n is 1.
- R2: The width of a pulse is the number of rising clock edges at which sync_n is sampled 0. The pulse is judged at the first edge where sync_n is sampled 1 again, and h_valid is 1 for exactly the one cycle that follows that edge.
- R3: With std_ntsc = 1, a pulse is accepted as a line pulse only if its width is between 36 and 76 inclusive. A width of 35 or 77 gives no h_valid.
- R4: With std_ntsc = 0, a pulse is accepted as a line pulse only if its width is between 40 and 97 inclusive. A width of 39 or 98 gives no h_valid.
- R5: burst_gate rises in the same cycle as h_valid. It stays high for 32 cycles in NTSC and 40 cycles in PAL. A rejected pulse leaves burst_gate low.
- R6: Any pulse wider than the upper window limit counts as broad. The next accepted line pulse asserts frame_start together with its h_valid. Narrow (equalizing) pulses in between do not cancel this. Later line pulses give no frame_start.
- R7: The width count saturates at 255. A pulse held low for 255 or more edges is always treated as broad and never as a line pulse.
- R8: Each value of sync_n sampled at a rising edge appears on sync_dly_n three edges later, through four register stages. The reset value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Four-times-subcarrier clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Composite sync, low during a pulse, synchronous to clk |
| std_ntsc | input | 1 | 1 selects NTSC limits, 0 selects PAL limits |
| h_valid | output | 1 | One-cycle strobe for an accepted line sync pulse |
| burst_gate | output | 1 | High during the colour burst window |
| frame_start | output | 1 | One-cycle strobe on the first line pulse after a broad pulse |
| sync_dly_n | output | 1 | Delayed copy of sync_n |

## Verification
The pulse widths tried straddle each edge of the window: 35, 36, 76 and 77 in NTSC, and 39, 40, 97 and 98 in PAL. They show whether each comparison is inclusive and whether the limits follow the standard select. Broad pulses of 150 edges, and of 300 edges (which saturates the counter), are each followed by equalizing pulses and then line pulses. This sequence separates the frame-start rule from plain line acceptance and shows that equalizing pulses leave the pending frame state alone. The burst length, measured after each accepted pulse, distinguishes the 32-cycle and 40-cycle gates. The per-cycle comparison of the delayed sync output pins down its stage count.

// File: rtl/sync_sep_pkg.sv
package sync_sep_pkg;
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_SHORT = 2'd1,
    PK_LINE  = 2'd2,
    PK_BROAD = 2'd3
  } pulse_kind_e;
endpackage

// File: rtl/sync_pulse_meter.sv
module sync_pulse_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  output logic             end_o,
  output logic [CNT_W-1:0] width_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  // R2: width counts low samples; R7: the count holds at its top value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_n;
      if (sync_n)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign end_o   = sync_n & ~prev_q;
  assign width_o = cnt_q;
  assign sat_o   = (cnt_q == CNT_MAX);
endmodule

// File: rtl/sync_pulse_classifier.sv
module sync_pulse_classifier
  import sync_sep_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NTSC_LO = 36,
  parameter int NTSC_HI = 76,
  parameter int PAL_LO  = 40,
  parameter int PAL_HI  = 97
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             std_ntsc,
  input  logic             end_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             sat_i,
  output logic             accept_o,
  output logic             h_valid_o,
  output logic             frame_start_o
);
  localparam logic [CNT_W-1:0] N_LO = CNT_W'(NTSC_LO);
  localparam logic [CNT_W-1:0] N_HI = CNT_W'(NTSC_HI);
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(PAL_LO);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(PAL_HI);

  logic [CNT_W-1:0] lo_lim, hi_lim;
  pulse_kind_e      kind;
  logic             broad_q;

  assign lo_lim = std_ntsc ? N_LO : P_LO;
  assign hi_lim = std_ntsc ? N_HI : P_HI;

  // R3/R4: window chosen by standard; R7: saturated count is broad
  always_comb begin
    if (!end_i)               kind = PK_NONE;
    else if (sat_i)           kind = PK_BROAD;
    else if (width_i < lo_lim) kind = PK_SHORT;
    else if (width_i > hi_lim) kind = PK_BROAD;
    else                      kind = PK_LINE;
  end

  assign accept_o = (kind == PK_LINE);

  // R6: a broad pulse arms frame start until the next accepted line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_valid_o     <= 1'b0;
      frame_start_o <= 1'b0;
      broad_q       <= 1'b0;
    end else begin
      h_valid_o     <= accept_o;
      frame_start_o <= accept_o & broad_q;
      if (kind == PK_BROAD)  broad_q <= 1'b1;
      else if (accept_o)     broad_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_window.sv
module burst_window #(
  parameter int LEN_NTSC = 32,
  parameter int LEN_PAL  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std_ntsc,
  input  logic start_i,
  output logic gate_o
);
  localparam int LEN_MAX = (LEN_NTSC > LEN_PAL) ? LEN_NTSC : LEN_PAL;
  localparam int BW      = $clog2(LEN_MAX + 1);

  logic [BW-1:0] left_q;

  // R5: length loaded on accept, counted down to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (start_i)       left_q <= std_ntsc ? BW'(LEN_NTSC) : BW'(LEN_PAL);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign gate_o = (left_q != '0);
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // R8: fixed register chain, reset to the inactive level
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe_q[i] <= 1'b1;
      else if (i == 0) pipe_q[i] <= d_i;
      else             pipe_q[i] <= pipe_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sync_sep_gate.sv
module sync_sep_gate #(
  parameter int CNT_W      = 8,
  parameter int NTSC_LO    = 36,
  parameter int NTSC_HI    = 76,
  parameter int PAL_LO     = 40,
  parameter int PAL_HI     = 97,
  parameter int BURST_NTSC = 32,
  parameter int BURST_PAL  = 40,
  parameter int SYNC_DLY   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic std_ntsc,
  output logic h_valid,
  output logic burst_gate,
  output logic frame_start,
  output logic sync_dly_n
);
  logic             pulse_end;
  logic [CNT_W-1:0] pulse_width;
  logic             pulse_sat;
  logic             accept;

  sync_pulse_meter #(.CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_n  (sync_n),
    .end_o   (pulse_end),
    .width_o (pulse_width),
    .sat_o   (pulse_sat)
  );

  sync_pulse_classifier #(
    .CNT_W(CNT_W), .NTSC_LO(NTSC_LO), .NTSC_HI(NTSC_HI),
    .PAL_LO(PAL_LO), .PAL_HI(PAL_HI)
  ) u_class (
    .clk           (clk),
    .rst_n         (rst_n),
    .std_ntsc      (std_ntsc),
    .end_i         (pulse_end),
    .width_i       (pulse_width),
    .sat_i         (pulse_sat),
    .accept_o      (accept),
    .h_valid_o     (h_valid),
    .frame_start_o (frame_start)
  );

  burst_window #(.LEN_NTSC(BURST_NTSC), .LEN_PAL(BURST_PAL)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .std_ntsc (std_ntsc),
    .start_i  (accept),
    .gate_o   (burst_gate)
  );

  sync_delay_line #(.STAGES(SYNC_DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_n),
    .q_o   (sync_dly_n)
  );
endmodule

// File: rtl/sync_sep_gate_chk.sv
module sync_sep_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_n,
  input logic h_valid,
  input logic burst_gate,
  input logic frame_start
);
  // R2
  hv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |=> !h_valid);

  // R2
  hv_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> ($past(sync_n) && !$past(sync_n, 2)));

  // R5
  burst_with_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |-> burst_gate);

  // R5
  burst_open_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_gate) |-> h_valid);

  // R6
  frame_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> h_valid);
endmodule

bind sync_sep_gate sync_sep_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_n      (sync_n),
  .h_valid     (h_valid),
  .burst_gate  (burst_gate),
  .frame_start (frame_start)
);

// File: tb/test_sync_sep_gate.sv
module test_sync_sep_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic std_ntsc = 1'b1;
  logic h_valid, burst_gate, frame_start, sync_dly_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_sep_gate i_sync_sep_gate (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .std_ntsc(std_ntsc),
    .h_valid(h_valid), .burst_gate(burst_gate),
    .frame_start(frame_start), .sync_dly_n(sync_dly_n)
  );

  // behavioural reference
  int m_cnt, m_prev, m_hv, m_fs, m_bg, m_broad, m_dly;
  bit m_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = 1; m_hv = 0; m_fs = 0; m_bg = 0; m_broad = 0;
      m_dly = 1;
      m_hist.delete();
      repeat (3) m_hist.push_back(1'b1);
    end else begin
      int lo, hi;
      bit loaded;
      lo = std_ntsc ? 36 : 40;
      hi = std_ntsc ? 76 : 97;
      loaded = 0;
      m_hv = 0; m_fs = 0;
      if (sync_n && m_prev == 0) begin
        if (m_cnt >= lo && m_cnt <= hi && m_cnt < 255) begin
          m_hv = 1; m_fs = m_broad; m_broad = 0;
          m_bg = std_ntsc ? 32 : 40; loaded = 1;
        end else if (m_cnt > hi) begin
          m_broad = 1;
        end
      end
      if (!loaded && m_bg > 0) m_bg--;
      if (!sync_n) m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
      else m_cnt = 0;
      m_prev = sync_n;
      m_hist.push_back(sync_n);
      m_dly = m_hist.pop_front();
    end
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and pulse observation, away from the active edge
  int seen_hv, seen_fs, bg_cycles;
  always @(negedge clk) begin
    if (!done) begin
      check("R2 h_valid", h_valid, m_hv);
      check("R5 burst_gate", burst_gate, (m_bg > 0) ? 1 : 0);
      check("R6 frame_start", frame_start, m_fs);
      check("R8 sync_dly_n", sync_dly_n, m_dly);
      seen_hv += h_valid;
      seen_fs += frame_start;
      bg_cycles += burst_gate;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic line(int w, bit ok, bit fs, string tag);
    seen_hv = 0; seen_fs = 0; bg_cycles = 0;
    repeat (w) begin @(negedge clk); sync_n = 1'b0; end
    repeat (150) begin @(negedge clk); sync_n = 1'b1; end
    check({tag, " accept"}, seen_hv, ok ? 1 : 0);
    check("R5 burst length", bg_cycles, ok ? (std_ntsc ? 32 : 40) : 0);
    check("R6 frame start", seen_fs, fs ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 h_valid", h_valid, 0);
    check("R1 burst_gate", burst_gate, 0);
    check("R1 frame_start", frame_start, 0);
    check("R1 sync_dly_n", sync_dly_n, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R3 NTSC window edges
    line(35, 0, 0, "R3");
    line(36, 1, 0, "R3");
    line(76, 1, 0, "R3");
    line(77, 0, 0, "R3");   // wider than window: broad
    line(50, 1, 1, "R6");
    line(50, 1, 0, "R6");
    // vertical interval: broad, saturated, equalizing
    line(150, 0, 0, "R6");
    line(300, 0, 0, "R7");
    line(18, 0, 0, "R6");
    line(18, 0, 0, "R6");
    line(60, 1, 1, "R6");
    line(60, 1, 0, "R3");
    line(255, 0, 0, "R7");
    line(40, 1, 1, "R7");

    // R4 PAL window edges
    std_ntsc = 1'b0;
    repeat (5) @(negedge clk);
    line(39, 0, 0, "R4");
    line(40, 1, 0, "R4");
    line(97, 1, 0, "R4");
    line(98, 0, 0, "R4");
    line(70, 1, 1, "R4");

    repeat (10) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule